// File: doc/BRIEF.md
# Lockable Set-Associative Instruction Cache

This block sits between the instruction fetch unit and the memory path. It takes one fetch address per cycle and looks it up in a set-associative tag store. On a hit it returns a group of four consecutive instructions on the next cycle. On a miss it asks memory for the whole line and collects the line one word per beat. It then returns the requested group and, where allowed, writes the line into a victim way. The choice of victim prefers an empty way and otherwise follows a tree pseudo-LRU order.

Software steers the cache through three level and pulse inputs. An enable level turns lookups on or off. A lock level freezes the contents, so hits are still served but misses never allocate. A flash pulse clears every line with a sweep of one set per cycle. A single block can also be dropped by presenting any byte address inside it. Each line carries only a valid bit.

Top module: `lockable_icache`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1 and `resp_valid`, `mem_req_valid` and `inv_busy` are 0.
- R2: A fetch accepted (`fetch_valid` and `fetch_ready` high at a clock edge) that hits, while enabled, raises `resp_valid` on the very next cycle with no memory request. Word i (0..3) of the aligned 16-byte group holding the address is placed in `resp_data[32*i +: 32]`.
- R3: A miss issues exactly one request whose address is the fetch address with its low 5 bits cleared. Eight 32-bit beats follow, in ascending word order. The requested group is returned in the cycle after the last beat. The line is allocated when enabled and not locked.
- R4: From the acceptance of a miss until its response cycle, `fetch_ready` stays low.
- R5: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, a tree pseudo-LRU picks the victim: the ways filled in order 0,1,2,3 and then way 0 hit give way 2 as the victim.
- R6: With `ctl_lock` high, hits are served from the cache. Misses are served from memory and leave the cache unchanged, so a repeated miss goes to memory again.
- R7: With `ctl_enable` low, every fetch is served from memory and nothing is allocated. Lines that were valid before stay valid and hit again once `ctl_enable` returns high.
- R8: A one-cycle `binv_valid` clears only the line containing `binv_addr`. Other lines keep hitting.
- R9: A `ctl_flash_inv` pulse makes `inv_busy` high for exactly 16 cycles, starting the cycle after the pulse. `fetch_ready` is low while it runs. Pulses during the sweep are ignored. Afterwards every line is invalid, also when the pulse is given together with `ctl_enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Cache lookups and allocation enabled |
| ctl_lock | input | 1 | Freeze contents: no allocation on a miss |
| ctl_flash_inv | input | 1 | Pulse: start clearing all lines |
| inv_busy | output | 1 | Flash sweep in progress |
| binv_valid | input | 1 | Invalidate the line holding `binv_addr` |
| binv_addr | input | 32 | Byte address for block invalidate |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch accepted at this edge when valid |
| resp_valid | output | 1 | Instruction group valid |
| resp_data | output | 128 | Four instructions, lowest address in bits 31:0 |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_addr | output | 32 | Line-aligned refill address |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_data | input | 32 | Refill beat word |

## Verification
A wrong valid bit or tag shows as a fetch whose memory-request count and response latency disagree with the expected hit or miss. It also returns data of the wrong memory generation. The bench changes the memory contents between fetches, so stale lines are told apart from fresh ones on the first fetch that touches them. A wrong pseudo-LRU state shows as a line that misses when it should hit. This appears within the four or five fetches that follow an eviction. A sweep that is too long or too short shows directly in the count of busy cycles. A line left valid after a flash shows on its next fetch.

// File: rtl/icache_pkg.sv
// Shared types of the instruction cache.
// Assumes nothing beyond IEEE 1800-2017.
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } fsm_t;
endpackage

// File: rtl/icache_tags.sv
// Tag store, valid bits and tree pseudo-LRU state for the instruction cache.
// Does lookup, victim choice, allocation, block invalidate and the flash sweep.
// Assumes WAYS is a power of two of at least 2 and SETS a power of two.
module icache_tags #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic [WAY_W-1:0] look_way,
    input  logic             touch_en,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             alloc_fire,
    output logic [WAY_W-1:0] alloc_way,
    input  logic             binv_en,
    input  logic [IDX_W-1:0] binv_idx,
    input  logic [TAG_W-1:0] binv_tag,
    input  logic             flash_req,
    output logic             busy
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  plru_q  [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             busy_q;
    logic [IDX_W-1:0] sweep_q;
    logic [WAYS-1:0]  binv_match;
    logic             same_line;
    logic             any_valid;

    // Walk the tree from the root along the pointer bits to a leaf.
    function automatic logic [WAY_W-1:0] plru_pick(input logic [WAYS-1:0] t);
        logic [WAY_W-1:0] node = WAY_W'(1);
        logic [WAY_W-1:0] way  = '0;
        for (int l = 0; l < WAY_W; l++) begin
            way  = (way << 1) | WAY_W'(t[node]);
            node = (node << 1) | WAY_W'(t[node]);
        end
        return way;
    endfunction

    // Point every node on the path of the used way away from it.
    function automatic logic [WAYS-1:0] plru_touch(input logic [WAYS-1:0] t,
                                                   input logic [WAY_W-1:0] way);
        logic [WAYS-1:0]  r    = t;
        logic [WAY_W-1:0] node = WAY_W'(1);
        logic [WAY_W-1:0] w    = way;
        for (int l = 0; l < WAY_W; l++) begin
            r[node] = ~w[WAY_W-1];
            node    = (node << 1) | WAY_W'(w[WAY_W-1]);
            w       = w << 1;
        end
        return r;
    endfunction

    // Tag compare on the lookup set; the lowest matching way wins.
    always_comb begin
        look_hit = 1'b0;
        look_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_q[look_idx][w] && tag_q[look_idx][w] == look_tag) begin
                look_hit = 1'b1;
                look_way = WAY_W'(w);
            end
        end
    end

    // Victim for the refill set: lowest invalid way first, else pseudo-LRU.
    always_comb begin
        alloc_way = plru_pick(plru_q[fill_idx]);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[fill_idx][w]) alloc_way = WAY_W'(w);
        end
    end

    // Block invalidate match, and suppression of a fill of the line being dropped.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            binv_match[w] = valid_q[binv_idx][w] && tag_q[binv_idx][w] == binv_tag;
        end
        same_line = binv_en && binv_idx == fill_idx && binv_tag == fill_tag;
    end

    assign alloc_fire = fill_en && !busy_q && !flash_req && !same_line;
    assign busy       = busy_q;

    // Valid bits, pseudo-LRU state and the flash sweep pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                plru_q[s]  <= '0;
            end
            busy_q  <= 1'b0;
            sweep_q <= '0;
        end else begin
            if (busy_q) begin
                valid_q[sweep_q] <= '0;
                sweep_q          <= sweep_q + 1'b1;
                if (sweep_q == IDX_W'(SETS - 1)) busy_q <= 1'b0;
            end else if (flash_req) begin
                busy_q  <= 1'b1;
                sweep_q <= '0;
            end
            if (binv_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (binv_match[w]) valid_q[binv_idx][w] <= 1'b0;
                end
            end
            if (alloc_fire) valid_q[fill_idx][alloc_way] <= 1'b1;
            if (touch_en)   plru_q[look_idx] <= plru_touch(plru_q[look_idx], look_way);
            if (alloc_fire) plru_q[fill_idx] <= plru_touch(plru_q[fill_idx], alloc_way);
        end
    end

    // Tag write on allocation; tags need no reset because valid bits guard them.
    always_ff @(posedge clk) begin
        if (alloc_fire) tag_q[fill_idx][alloc_way] <= fill_tag;
    end

    // Any line still valid, for the sweep-completion check.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    a_r9_sweep_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> !any_valid);

    a_r5_invalid_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !(&valid_q[fill_idx])) |-> !valid_q[fill_idx][alloc_way]);

    a_r8_binv_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (binv_en && binv_idx == look_idx && binv_tag == look_tag) |=>
            !($past(look_idx) == look_idx && $past(look_tag) == look_tag && look_hit));
endmodule

// File: rtl/icache_data.sv
// Instruction word storage: one read port returning a fetch group,
// one write port taking a whole line. Assumes LINE_WORDS = FETCH_WORDS * 2^k, k >= 1.
module icache_data #(
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int LINE_WORDS  = 8,
    parameter int FETCH_WORDS = 4,
    parameter int DATA_W      = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int FW_W  = $clog2(FETCH_WORDS),
    localparam int GRP_W = $clog2(LINE_WORDS / FETCH_WORDS)
) (
    input  logic                          clk,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [WAY_W-1:0]              rd_way,
    input  logic [GRP_W-1:0]              rd_grp,
    output logic [FETCH_WORDS*DATA_W-1:0] rd_data,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [LINE_WORDS*DATA_W-1:0]  wr_line
);
    logic [DATA_W-1:0] mem_q [SETS][WAYS][LINE_WORDS];

    // Read the addressed fetch group out of one way.
    always_comb begin
        for (int i = 0; i < FETCH_WORDS; i++) begin
            rd_data[i*DATA_W +: DATA_W] = mem_q[rd_idx][rd_way][{rd_grp, FW_W'(i)}];
        end
    end

    // Write a complete refilled line into the chosen way.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < LINE_WORDS; k++) begin
                mem_q[wr_idx][wr_way][k] <= wr_line[k*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/icache_ctrl.sv
// Fetch sequencer: serves hits in one cycle, runs line refills on a miss,
// gathers the refill beats and returns the requested group after the last beat.
// Assumes memory returns LINE_WORDS beats in ascending order after each request.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 8,
    parameter int FETCH_WORDS = 4,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int FW_W   = $clog2(FETCH_WORDS),
    localparam int GRP_W  = OFF_W - FW_W,
    localparam int LINE_B = OFF_W + BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_valid,
    input  logic [ADDR_W-1:0]             fetch_addr,
    output logic                          fetch_ready,
    input  logic                          look_hit,
    input  logic [FETCH_WORDS*DATA_W-1:0] hit_data,
    input  logic                          cache_on,
    input  logic                          alloc_ok,
    input  logic                          inv_busy,
    output logic                          touch_en,
    output logic                          resp_valid,
    output logic [FETCH_WORDS*DATA_W-1:0] resp_data,
    output logic                          mem_req_valid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_req_ready,
    input  logic                          mem_rsp_valid,
    input  logic [DATA_W-1:0]             mem_rsp_data,
    output logic                          fill_en,
    output logic [ADDR_W-1:0]             fill_addr,
    output logic [LINE_WORDS*DATA_W-1:0]  fill_line
);
    fsm_t                         state_q;
    logic [ADDR_W-1:0]            miss_q;
    logic [OFF_W-1:0]             beat_q;
    logic [LINE_WORDS*DATA_W-1:0] buf_q;
    logic [GRP_W-1:0]             miss_grp;
    logic [FETCH_WORDS*DATA_W-1:0] miss_group;
    logic                         accept;
    logic                         last_beat;
    logic                         unused_bits;

    assign fetch_ready   = state_q == ST_IDLE && !inv_busy;
    assign accept        = fetch_valid && fetch_ready;
    assign touch_en      = accept && look_hit && cache_on;
    assign mem_req_valid = state_q == ST_REQ;
    assign mem_req_addr  = {miss_q[ADDR_W-1:LINE_B], LINE_B'(0)};
    assign last_beat     = state_q == ST_FILL && mem_rsp_valid && beat_q == OFF_W'(LINE_WORDS - 1);
    assign fill_en       = last_beat && alloc_ok;
    assign fill_addr     = miss_q;
    assign miss_grp      = miss_q[LINE_B-1 -: GRP_W];
    assign unused_bits   = ^miss_q[BYTE_W+FW_W-1:0];

    // Refill line with the arriving beat merged into its slot.
    always_comb begin
        fill_line = buf_q;
        fill_line[beat_q*DATA_W +: DATA_W] = mem_rsp_data;
        for (int i = 0; i < FETCH_WORDS; i++) begin
            miss_group[i*DATA_W +: DATA_W] = fill_line[{miss_grp, FW_W'(i)}*DATA_W +: DATA_W];
        end
    end

    // Sequencer state, miss address, beat counter and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            miss_q     <= '0;
            beat_q     <= '0;
            buf_q      <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (touch_en) begin
                        resp_valid <= 1'b1;
                        resp_data  <= hit_data;
                    end else if (accept) begin
                        miss_q  <= fetch_addr;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        beat_q  <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        buf_q  <= fill_line;
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            resp_valid <= 1'b1;
                            resp_data  <= miss_group;
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && look_hit && cache_on) |=> resp_valid);

    a_r4_stall_during_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_rsp_valid) |-> !fetch_ready);
endmodule

// File: rtl/lockable_icache.sv
// Top of the lockable instruction cache: splits addresses, wires the tag store,
// data store and fetch sequencer, and applies enable and lock to hits and fills.
// Assumes single-cycle combinational tag and data reads.
module lockable_icache #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int LINE_WORDS  = 8,
    parameter int FETCH_WORDS = 4,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int GRP_W  = $clog2(LINE_WORDS / FETCH_WORDS),
    localparam int LINE_B = OFF_W + BYTE_W,
    localparam int TAG_W  = ADDR_W - IDX_W - LINE_B
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_enable,
    input  logic                          ctl_lock,
    input  logic                          ctl_flash_inv,
    output logic                          inv_busy,
    input  logic                          binv_valid,
    input  logic [ADDR_W-1:0]             binv_addr,
    input  logic                          fetch_valid,
    input  logic [ADDR_W-1:0]             fetch_addr,
    output logic                          fetch_ready,
    output logic                          resp_valid,
    output logic [FETCH_WORDS*DATA_W-1:0] resp_data,
    output logic                          mem_req_valid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_req_ready,
    input  logic                          mem_rsp_valid,
    input  logic [DATA_W-1:0]             mem_rsp_data
);
    logic                          look_hit;
    logic [WAY_W-1:0]              look_way;
    logic                          touch_en;
    logic                          fill_en;
    logic [ADDR_W-1:0]             fill_addr;
    logic [LINE_WORDS*DATA_W-1:0]  fill_line;
    logic                          alloc_fire;
    logic [WAY_W-1:0]              alloc_way;
    logic [FETCH_WORDS*DATA_W-1:0] hit_data;
    logic                          unused_addr;

    assign unused_addr = ^{fetch_addr[LINE_B-GRP_W-1:0], binv_addr[LINE_B-1:0], fill_addr[LINE_B-1:0]};

    icache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (fetch_addr[LINE_B +: IDX_W]),
        .look_tag   (fetch_addr[ADDR_W-1 -: TAG_W]),
        .look_hit   (look_hit),
        .look_way   (look_way),
        .touch_en   (touch_en),
        .fill_en    (fill_en),
        .fill_idx   (fill_addr[LINE_B +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .alloc_fire (alloc_fire),
        .alloc_way  (alloc_way),
        .binv_en    (binv_valid),
        .binv_idx   (binv_addr[LINE_B +: IDX_W]),
        .binv_tag   (binv_addr[ADDR_W-1 -: TAG_W]),
        .flash_req  (ctl_flash_inv),
        .busy       (inv_busy)
    );

    icache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS),
                  .FETCH_WORDS(FETCH_WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (fetch_addr[LINE_B +: IDX_W]),
        .rd_way  (look_way),
        .rd_grp  (fetch_addr[LINE_B-1 -: GRP_W]),
        .rd_data (hit_data),
        .wr_en   (alloc_fire),
        .wr_idx  (fill_addr[LINE_B +: IDX_W]),
        .wr_way  (alloc_way),
        .wr_line (fill_line)
    );

    icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
                  .FETCH_WORDS(FETCH_WORDS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_ready   (fetch_ready),
        .look_hit      (look_hit),
        .hit_data      (hit_data),
        .cache_on      (ctl_enable),
        .alloc_ok      (ctl_enable && !ctl_lock),
        .inv_busy      (inv_busy),
        .touch_en      (touch_en),
        .resp_valid    (resp_valid),
        .resp_data     (resp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fill_en       (fill_en),
        .fill_addr     (fill_addr),
        .fill_line     (fill_line)
    );

    // R6 and R7: a line is only written while enabled and unlocked.
    a_r6_no_alloc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> (ctl_enable && !ctl_lock));

    a_r9_busy_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> !fetch_ready);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!resp_valid && !mem_req_valid && !inv_busy));
endmodule

// File: tb/tb_lockable_icache.sv
`timescale 1ns/1ps
module tb_lockable_icache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_enable = 1'b1;
    logic         ctl_lock = 1'b0;
    logic         ctl_flash_inv = 1'b0;
    logic         inv_busy;
    logic         binv_valid = 1'b0;
    logic [31:0]  binv_addr = '0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_ready;
    logic         resp_valid;
    logic [127:0] resp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_req_ready = 1'b0;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;

    int          n_checks = 0;
    int          n_fail = 0;
    int          req_count = 0;
    logic [31:0] last_req_addr = '0;
    logic [7:0]  mem_gen = 8'd0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lockable_icache dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_lock(ctl_lock),
        .ctl_flash_inv(ctl_flash_inv), .inv_busy(inv_busy), .binv_valid(binv_valid),
        .binv_addr(binv_addr), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] mem_word(input logic [7:0] g, input logic [31:0] a);
        return {g, a[23:0]};
    endfunction

    // Memory model: ready one cycle late, eight beats with one bubble after the fourth.
    int          mstate = 0;
    int          slot = 0;
    logic [31:0] base_q = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mstate <= 0; mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0;
        end else begin
            case (mstate)
                0: begin
                    mem_rsp_valid <= 1'b0;
                    if (mem_req_valid && mem_req_ready) begin
                        mem_req_ready <= 1'b0;
                        base_q        <= mem_req_addr;
                        last_req_addr <= mem_req_addr;
                        req_count     <= req_count + 1;
                        slot          <= 0;
                        mstate        <= 1;
                    end else if (mem_req_valid) begin
                        mem_req_ready <= 1'b1;
                    end
                end
                1: begin
                    if (slot == 4) mem_rsp_valid <= 1'b0;
                    else begin
                        mem_rsp_valid <= 1'b1;
                        mem_rsp_data  <= mem_word(mem_gen, base_q + 32'(4 * (slot < 4 ? slot : slot - 1)));
                    end
                    if (slot == 8) mstate <= 2;
                    slot <= slot + 1;
                end
                default: begin
                    mem_rsp_valid <= 1'b0;
                    mstate <= 0;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit exp_miss,
                            input logic [7:0] eg, input string rq);
        int rc0; int lat; bit stall_ok; logic [127:0] exp;
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        while (!fetch_ready) @(negedge clk);
        rc0 = req_count;
        @(negedge clk);
        fetch_valid = 1'b0;
        lat = 1; stall_ok = 1'b1;
        while (!resp_valid && lat < 200) begin
            if (fetch_ready) stall_ok = 1'b0;
            lat++;
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) exp[i*32 +: 32] = mem_word(eg, (a & ~32'hF) + 32'(4 * i));
        if (exp_miss) begin
            chk(req_count == rc0 + 1 && lat > 1 && lat < 200,
                $sformatf("%s miss @%h: reqs %0d latency %0d, expected reqs %0d", rq, a, req_count - rc0, lat, 1));
            chk(last_req_addr == (a & ~32'h1F),
                $sformatf("R3 request addr %h, expected %h", last_req_addr, a & ~32'h1F));
            chk(stall_ok, $sformatf("R4 fetch_ready high during refill of %h: %0d expected 0", a, !stall_ok));
        end else begin
            chk(req_count == rc0 && lat == 1,
                $sformatf("%s hit @%h: reqs %0d latency %0d, expected 0 and 1", rq, a, req_count - rc0, lat));
        end
        chk(resp_data == exp, $sformatf("%s data @%h: %h expected %h", rq, a, resp_data, exp));
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  gen;
        logic        miss;
        logic [7:0]  egen;
        logic [1:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 8'd1, 1'b1, 8'd1, 2'd1},
        '{32'h0000_0000, 8'd2, 1'b0, 8'd1, 2'd0},
        '{32'h0000_0010, 8'd2, 1'b0, 8'd1, 2'd0},
        '{32'h0000_0200, 8'd2, 1'b1, 8'd2, 2'd1},
        '{32'h0000_0400, 8'd3, 1'b1, 8'd3, 2'd1},
        '{32'h0000_0600, 8'd3, 1'b1, 8'd3, 2'd1},
        '{32'h0000_0000, 8'd4, 1'b0, 8'd1, 2'd2},
        '{32'h0000_0800, 8'd4, 1'b1, 8'd4, 2'd2},
        '{32'h0000_0200, 8'd5, 1'b0, 8'd2, 2'd2},
        '{32'h0000_0600, 8'd5, 1'b0, 8'd3, 2'd2},
        '{32'h0000_0000, 8'd5, 1'b0, 8'd1, 2'd2},
        '{32'h0000_0810, 8'd5, 1'b0, 8'd4, 2'd2},
        '{32'h0000_0400, 8'd5, 1'b1, 8'd5, 2'd2},
        '{32'h0000_1020, 8'd5, 1'b1, 8'd5, 2'd1}
    };

    initial begin
        int busy_cycles;
        string rq;
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        chk(fetch_ready && !resp_valid && !mem_req_valid && !inv_busy,
            $sformatf("R1 reset outputs rdy %0d rv %0d req %0d busy %0d, expected 1 0 0 0",
                      fetch_ready, resp_valid, mem_req_valid, inv_busy));
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_ready && !resp_valid && !mem_req_valid && !inv_busy,
            $sformatf("R1 after release rdy %0d busy %0d, expected 1 0", fetch_ready, inv_busy));

        // R2 R3 R5: table walk over hits, misses and a pseudo-LRU eviction
        for (int v = 0; v < NV; v++) begin
            mem_gen = VECS[v].gen;
            rq = (VECS[v].req == 2'd0) ? "R2" : (VECS[v].req == 2'd1) ? "R3" : "R5";
            if (v == 0) rq = "R1";
            do_fetch(VECS[v].addr, VECS[v].miss, VECS[v].egen, rq);
        end

        // R6: locked, misses never allocate, hits still served
        ctl_lock = 1'b1;
        mem_gen = 8'd6; do_fetch(32'h0000_3000, 1'b1, 8'd6, "R6");
        mem_gen = 8'd7; do_fetch(32'h0000_3000, 1'b1, 8'd7, "R6");
        do_fetch(32'h0000_1020, 1'b0, 8'd5, "R6");
        ctl_lock = 1'b0;

        // R7: disabled, pass-through, contents kept
        ctl_enable = 1'b0;
        mem_gen = 8'd8; do_fetch(32'h0000_1020, 1'b1, 8'd8, "R7");
        mem_gen = 8'd9; do_fetch(32'h0000_1020, 1'b1, 8'd9, "R7");
        ctl_enable = 1'b1;
        do_fetch(32'h0000_1020, 1'b0, 8'd5, "R7");

        // R8: block invalidate by an address inside the line
        @(negedge clk); binv_valid = 1'b1; binv_addr = 32'h0000_103C;
        @(negedge clk); binv_valid = 1'b0;
        mem_gen = 8'd10;
        do_fetch(32'h0000_0000, 1'b0, 8'd1, "R8");
        do_fetch(32'h0000_0810, 1'b0, 8'd4, "R8");
        do_fetch(32'h0000_1020, 1'b1, 8'd10, "R8");

        // R9: flash with enable low, bounded sweep, then everything misses
        @(negedge clk); ctl_enable = 1'b0; ctl_flash_inv = 1'b1;
        @(negedge clk); ctl_flash_inv = 1'b0;
        chk(inv_busy && !fetch_ready,
            $sformatf("R9 busy %0d ready %0d after pulse, expected 1 0", inv_busy, fetch_ready));
        busy_cycles = 0;
        while (inv_busy && busy_cycles < 100) begin
            busy_cycles++;
            if (busy_cycles == 5) ctl_flash_inv = 1'b1;
            if (busy_cycles == 6) ctl_flash_inv = 1'b0;
            @(negedge clk);
        end
        chk(busy_cycles == 16, $sformatf("R9 busy cycles %0d, expected 16", busy_cycles));
        chk(!inv_busy && fetch_ready,
            $sformatf("R9 extra pulse restarted sweep: busy %0d, expected 0", inv_busy));
        ctl_enable = 1'b1;
        mem_gen = 8'd11;
        do_fetch(32'h0000_0000, 1'b1, 8'd11, "R9");
        do_fetch(32'h0000_0810, 1'b1, 8'd11, "R9");
        do_fetch(32'h0000_0000, 1'b0, 8'd11, "R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: run incomplete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule